// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block sits behind the software-interrupt trigger register of an interrupt distributor. A CPU writes one 32-bit word to request a software interrupt. The dispatcher decodes that word and works out which CPUs receive the interrupt. One clock cycle later it emits a set-pending pulse vector with one bit per CPU. The pulse carries the interrupt number and a one-hot mask that names the requesting CPU. The downstream pending store ORs that mask into the source mask of each target's copy of the interrupt.

The word holds three fields that the block uses:
- the interrupt number, in bits [3:0];
- an explicit target list, in bits [23:16], one bit per CPU;
- a two-bit selection mode, in bits [25:24].

The mode decides how the target list is formed:
- mode 0 uses the written list;
- mode 1 selects every online CPU except the requester;
- mode 2 selects only the requester;
- mode 3 is reserved and does nothing.

Whatever the mode, the block never selects a CPU whose number is at or above the online CPU count. Reads of the register return zero. The block keeps no pending state and does not arbitrate between interrupts.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pend_vld`, `pend_intid` and `pend_src` are all zero. A write presented during reset produces no pulse.
- R2: In mode 0 (bits [25:24] = 0), `pend_vld` in the cycle after the write equals bits [23:16] ANDed with the online mask. The online mask has bit i set when i < `online_cnt`.
- R3: In mode 1, `pend_vld` equals the online mask with the requester's bit (`req_cpu`) cleared. The written list is ignored.
- R4: In mode 2, `pend_vld` has only the requester's bit set, and only if the requester is below `online_cnt`. The written list is ignored.
- R5: In mode 3, a write produces no pulse (`pend_vld` stays zero).
- R6: `pend_intid` equals bits [3:0] of the written word. Bits [15:4] and [31:26] have no effect on any output.
- R7: When any bit of `pend_vld` is set, `pend_src` is one-hot with bit `req_cpu` set.
- R8: `rd_data` is always zero.
- R9: A pulse lasts exactly one cycle. In a cycle that does not follow a write, `pend_vld` is zero.
- R10: Whenever `pend_vld` is zero, `pend_intid` and `pend_src` are also zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 32 | Word written to the trigger register |
| req_cpu | input | 3 | Number of the CPU issuing the write |
| online_cnt | input | 4 | Number of CPUs present (0 to 8) |
| rd_data | output | 32 | Read value of the trigger register, always zero |
| pend_vld | output | 8 | Set-pending pulse, one bit per target CPU |
| pend_intid | output | 4 | Interrupt number carried with the pulse |
| pend_src | output | 8 | One-hot requester mask carried with the pulse |

## Verification
The assertions check these properties on every cycle:
- a reserved-mode write and a cycle with no write both leave the pulse vector empty;
- no pulse bit lands at or above the online count seen at the write;
- a broadcast-to-others write never hits the requester;
- the source mask is one-hot while a pulse is out;
- interrupt number and source mask are clean while no pulse is out.

The bench scenarios show the exact target sets and interrupt numbers for each mode. They include:
- lists clipped by a small online count;
- self-targeting by a CPU that is not online;
- junk in the unused bits of the word;
- a write made while reset is held.

// File: rtl/sgi_pkg.sv
// Package: shared field positions and the target-selection mode type for
// the software-interrupt dispatcher. Assumes the 32-bit trigger word
// layout described in the brief.
package sgi_pkg;
    localparam int WORD_W    = 32;
    localparam int INTID_LSB = 0;
    localparam int INTID_W   = 4;
    localparam int LIST_LSB  = 16;
    localparam int MODE_LSB  = 24;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        SEL_LIST   = 2'd0,
        SEL_OTHERS = 2'd1,
        SEL_SELF   = 2'd2,
        SEL_RSVD   = 2'd3
    } sel_mode_e;
endpackage

// File: rtl/sgi_field_decode.sv
// Splits a trigger word into interrupt number, target list and mode.
// Assumes N_CPU <= 8 so the list fits in its 8-bit field.
module sgi_field_decode
    import sgi_pkg::*;
#(
    parameter int N_CPU = 8
) (
    input  logic [WORD_W-1:0]  word,
    output logic [INTID_W-1:0] intid,
    output logic [N_CPU-1:0]   list,
    output sel_mode_e          mode
);
    logic unused_fields;

    // Pull out the three fields; the remaining bits are deliberately dropped.
    always_comb begin
        intid = word[INTID_LSB +: INTID_W];
        list  = word[LIST_LSB +: N_CPU];
        mode  = sel_mode_e'(word[MODE_LSB +: MODE_W]);
        unused_fields = ^{word[LIST_LSB-1:INTID_LSB+INTID_W],
                          word[WORD_W-1:MODE_LSB+MODE_W]};
    end
endmodule

// File: rtl/sgi_target_filter.sv
// Turns mode, written list and requester into the final target set, with
// every CPU at or above the online count removed. Assumes req < N_CPU.
module sgi_target_filter
    import sgi_pkg::*;
#(
    parameter int N_CPU = 8,
    localparam int ID_W  = $clog2(N_CPU),
    localparam int CNT_W = $clog2(N_CPU + 1)
) (
    input  sel_mode_e        mode,
    input  logic [N_CPU-1:0] list,
    input  logic [ID_W-1:0]  req,
    input  logic [CNT_W-1:0] online_cnt,
    output logic [N_CPU-1:0] targets
);
    logic [N_CPU-1:0] online_mask;
    logic [N_CPU-1:0] self_bit;

    // One comparator per CPU builds the online mask and the requester bit.
    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        assign online_mask[g] = online_cnt > CNT_W'(g);
        assign self_bit[g]    = req == ID_W'(g);
    end

    // Select the raw set by mode, then clip it to existing CPUs.
    always_comb begin
        unique case (mode)
            SEL_LIST:   targets = list;
            SEL_OTHERS: targets = ~self_bit;
            SEL_SELF:   targets = self_bit;
            default:    targets = '0;
        endcase
        targets = targets & online_mask;
    end
endmodule

// File: rtl/sgi_pulse_reg.sv
// Registers the one-cycle set-pending pulse with its interrupt number and
// one-hot source mask. The payload is zeroed whenever no target is set.
module sgi_pulse_reg
    import sgi_pkg::*;
#(
    parameter int N_CPU = 8,
    localparam int ID_W = $clog2(N_CPU)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [N_CPU-1:0]   targets,
    input  logic [INTID_W-1:0] intid,
    input  logic [ID_W-1:0]    req,
    output logic [N_CPU-1:0]   vld_q,
    output logic [INTID_W-1:0] intid_q,
    output logic [N_CPU-1:0]   src_q
);
    logic [N_CPU-1:0] req_onehot;
    logic             any_hit;

    // Decode the requester number into its source-mask bit.
    for (genvar g = 0; g < N_CPU; g++) begin : g_src
        assign req_onehot[g] = req == ID_W'(g);
    end

    assign any_hit = fire && (targets != '0);

    // Capture a pulse for one cycle; clear it on reset or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !any_hit) begin
            vld_q   <= '0;
            intid_q <= '0;
            src_q   <= '0;
        end else begin
            vld_q   <= targets;
            intid_q <= intid;
            src_q   <= req_onehot;
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Top of the software-interrupt dispatcher. Decodes a trigger-register
// write and emits, one cycle later, a set-pending pulse per target CPU.
// Assumes at most one write per cycle and req_cpu below N_CPU.
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int N_CPU = 8,
    localparam int ID_W  = $clog2(N_CPU),
    localparam int CNT_W = $clog2(N_CPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [ID_W-1:0]    req_cpu,
    input  logic [CNT_W-1:0]   online_cnt,
    output logic [WORD_W-1:0]  rd_data,
    output logic [N_CPU-1:0]   pend_vld,
    output logic [INTID_W-1:0] pend_intid,
    output logic [N_CPU-1:0]   pend_src
);
    logic [INTID_W-1:0] dec_intid;
    logic [N_CPU-1:0]   dec_list;
    sel_mode_e          dec_mode;
    logic [N_CPU-1:0]   sel_targets;

    // The trigger register reads as zero.
    assign rd_data = '0;

    sgi_field_decode #(.N_CPU(N_CPU)) decode_i (
        .word  (wr_data),
        .intid (dec_intid),
        .list  (dec_list),
        .mode  (dec_mode)
    );

    sgi_target_filter #(.N_CPU(N_CPU)) filter_i (
        .mode       (dec_mode),
        .list       (dec_list),
        .req        (req_cpu),
        .online_cnt (online_cnt),
        .targets    (sel_targets)
    );

    sgi_pulse_reg #(.N_CPU(N_CPU)) pulse_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (wr_en),
        .targets (sel_targets),
        .intid   (dec_intid),
        .req     (req_cpu),
        .vld_q   (pend_vld),
        .intid_q (pend_intid),
        .src_q   (pend_src)
    );

    // Reserved mode never produces a pulse.
    p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_LSB +: MODE_W] == 2'd3) |=> pend_vld == '0);

    // No pulse without a write in the previous cycle.
    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> pend_vld == '0);

    // Pulses never reach CPUs at or above the online count.
    p_online_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pend_vld >> $past(online_cnt)) == '0);

    // Broadcast-to-others never includes the requester.
    p_skip_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[MODE_LSB +: MODE_W] == 2'd1) |=> !pend_vld[$past(req_cpu)]);

    // Source mask is one-hot while a pulse is out.
    p_src_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld != '0) |-> $onehot(pend_src));

    // Payload is clean while no pulse is out.
    p_idle_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld == '0) |-> (pend_src == '0 && pend_intid == '0));
endmodule

// File: tb/sgi_dispatch_tb_top.sv
`timescale 1ns/1ps
module sgi_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  req_cpu = '0;
    logic [3:0]  online_cnt = 4'd8;
    logic [31:0] rd_data;
    logic [7:0]  pend_vld;
    logic [3:0]  pend_intid;
    logic [7:0]  pend_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sgi_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .req_cpu(req_cpu), .online_cnt(online_cnt), .rd_data(rd_data),
        .pend_vld(pend_vld), .pend_intid(pend_intid), .pend_src(pend_src)
    );

    // Vector: {word, requester, online count, expected pulse vector}
    localparam int NV = 12;
    localparam logic [46:0] VEC [NV] = '{
        {32'h00A5_0003, 3'd0, 4'd8, 8'hA5},  // R2 list as written
        {32'h00FF_ABCF, 3'd1, 4'd5, 8'h1F},  // R2 R6 clipped list, junk [15:4]
        {32'h0100_0007, 3'd3, 4'd8, 8'hF7},  // R3 all but self
        {32'h01FF_0001, 3'd0, 4'd4, 8'h0E},  // R3 list ignored, small online
        {32'h0200_0009, 3'd6, 4'd8, 8'h40},  // R4 self only
        {32'h0211_0002, 3'd2, 4'd8, 8'h04},  // R4 list ignored
        {32'h03FF_0005, 3'd1, 4'd8, 8'h00},  // R5 reserved mode
        {32'h0000_0004, 3'd0, 4'd8, 8'h00},  // R2 empty list
        {32'hFC80_0001, 3'd5, 4'd8, 8'h80},  // R6 junk in [31:26]
        {32'h0100_0002, 3'd0, 4'd1, 8'h00},  // R3 alone online
        {32'h0200_000A, 3'd7, 4'd7, 8'h00},  // R4 requester not online
        {32'h00FF_0006, 3'd0, 4'd0, 8'h00}   // R2 nothing online
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        chk(req, {24'd0, pend_vld}, 32'd0);
        chk({req, " R10 intid"}, {28'd0, pend_intid}, 32'd0);
        chk({req, " R10 src"}, {24'd0, pend_src}, 32'd0);
    endtask

    initial begin
        // R1: write held during reset must not produce a pulse
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h00FF_0003;
        @(negedge clk);
        check_idle("R1 in reset");
        wr_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");
        chk("R8 read zero", rd_data, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] exp_vld;
            logic [3:0] exp_id;
            logic [7:0] exp_src;
            wr_data    = VEC[i][46:15];
            req_cpu    = VEC[i][14:12];
            online_cnt = VEC[i][11:8];
            exp_vld    = VEC[i][7:0];
            exp_id     = (exp_vld != 0) ? VEC[i][18:15] : 4'd0;
            exp_src    = (exp_vld != 0) ? (8'd1 << VEC[i][14:12]) : 8'd0;
            wr_en = 1'b1;
            @(negedge clk);
            wr_en = 1'b0;
            chk($sformatf("R2-mode vector %0d targets", i), {24'd0, pend_vld}, {24'd0, exp_vld});
            chk($sformatf("R6 vector %0d intid", i), {28'd0, pend_intid}, {28'd0, exp_id});
            chk($sformatf("R7 vector %0d src", i), {24'd0, pend_src}, {24'd0, exp_src});
            chk("R8 read zero", rd_data, 32'd0);
            @(negedge clk);
            check_idle("R9 pulse ends");
        end

        // R9: back-to-back writes give back-to-back distinct pulses
        online_cnt = 4'd8; req_cpu = 3'd4;
        wr_en = 1'b1; wr_data = 32'h0003_000B;
        @(negedge clk);
        wr_data = 32'h0200_000C;
        chk("R9 first of pair", {24'd0, pend_vld}, 32'h03);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 second of pair", {24'd0, pend_vld}, 32'h10);
        chk("R6 second intid", {28'd0, pend_intid}, 32'hC);
        @(negedge clk);
        check_idle("R9 after pair");

        // R1: reset asserted again clears state
        wr_en = 1'b1; wr_data = 32'h00FF_0001; rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset again");
        wr_en = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after second reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule